// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Bank

This block is the register bank that software uses to run an address translation unit. A 32-bit request port reaches a set of control, configuration and status registers. Through these registers software switches the unit between off, running and held modes. It also programs a page table base and a configuration word in which only some bits can be written, and it pulses TLB invalidation strobes. The translation datapath and the TLB sit outside this block. The block only drives their control pins and takes their event inputs.

The datapath reports faults as a bit vector, one bit per fault class, together with the faulting address. Any fault puts the unit in the held mode and sets the matching interrupt status bit. The fault address is stored in one of four capture registers, chosen by the kind of fault. While any status bit is still pending, the unit cannot be resumed. Software must clear the pending bits by writing ones, and then write the run code. The interrupt line stays high while any status bit is set.

Top module: `mmu_regfile`

## Requirements
- R1: After reset the control register reads 0x0 (off), the configuration, table base, interrupt status and status registers read 0, `irq` is low and no flush strobe is high.
- R2: Writing 0x0, 0x5 or 0x7 to offset 0x000 selects off, run or held mode, and reading offset 0x000 returns that code. Any other value written there has no effect. `xlate_en` is high only in run mode and `block_req` is high only in held mode.
- R3: A write to offset 0x004 stores only bits 0–15, 20, 22 and 24 (mask 0x0150FFFF). The other bits read back as 0 and appear as 0 on `cfg_q`.
- R4: Offset 0x014 holds a full 32-bit table base that reads back as written and drives `ptbase_q`.
- R5: Bit 0 of the status register at 0x008 reads 1 only when the unit is in held mode and `blocked_ack` is high.
- R6: A write at 0x00C with data bit 0 set gives `flush_all` high for exactly the one cycle after the write. A write at 0x010 with data bit 0 set gives a one-cycle `flush_entry` pulse, with `flush_vpn` equal to data bits [31:12]. The same writes with bit 0 clear give no pulse.
- R7: A `fault_evt` bit sets the interrupt status bit at the same position (read at 0x018). The bit positions are: 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write protection. A fault also forces held mode from the next cycle.
- R8: Fault addresses are captured as follows: a page fault at 0x024, write-side faults (bits 2, 6, 7) at 0x028, read-side faults (bits 1, 4, 5) at 0x02C, and a bus error at 0x030. A capture register keeps its first address until every status bit of its group has been cleared, and later faults in that group do not overwrite it.
- R9: Offset 0x034 reads the 11-bit version parameter in bits [31:21]: major number in version bits [10:7], minor number in bits [6:0]. All other bits read 0.
- R10: A run-code write is ignored while any interrupt status bit is set, so the unit stays held.
- R11: Writing ones to 0x01C clears those status bits. If a fault sets a bit in the same cycle that the bit is cleared, the bit stays set, and its group captures the new address.
- R12: `irq` is high exactly while any status bit is set. A read returns its data on `rsp_valid` in the cycle after the request. Reads of unmapped or write-only offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| fault_evt | input | 8 | Fault events from the datapath, one bit per class |
| fault_addr | input | 32 | Address belonging to the fault events |
| blocked_ack | input | 1 | Datapath has drained and is actually blocked |
| xlate_en | output | 1 | Translation running |
| block_req | output | 1 | Datapath asked to block |
| cfg_q | output | 32 | Masked configuration word |
| ptbase_q | output | 32 | Page table base |
| flush_all | output | 1 | One-cycle invalidate-all strobe |
| flush_entry | output | 1 | One-cycle invalidate-one-page strobe |
| flush_vpn | output | 20 | Page number for `flush_entry` |
| irq | output | 1 | Interrupt, high while any status bit is set |

The request port has no back-pressure: every request is taken in the cycle it is presented. Read responses cannot be stalled, so the consumer must take `rsp_rdata` in the cycle `rsp_valid` is high.

## Verification
Two functions can fall in the same cycle: a fault event arriving from the datapath and a software write that clears the same status bit. The bench drives both in one cycle on a page-fault bit that is already pending with an older address. It expects the bit to remain set and the page-fault capture register to hold the new address. A run-code write made while a bit is still pending is also checked: the control register must still read the held code.

// File: rtl/mmu_rf_pkg.sv
package mmu_rf_pkg;
  localparam int NFAULT = 8;
  localparam int NGRP   = 4;

  localparam logic [11:0] OFF_CTRL  = 12'h000;
  localparam logic [11:0] OFF_CFG   = 12'h004;
  localparam logic [11:0] OFF_STAT  = 12'h008;
  localparam logic [11:0] OFF_FLUSH = 12'h00C;
  localparam logic [11:0] OFF_FLENT = 12'h010;
  localparam logic [11:0] OFF_PTB   = 12'h014;
  localparam logic [11:0] OFF_ISTAT = 12'h018;
  localparam logic [11:0] OFF_ICLR  = 12'h01C;
  localparam logic [11:0] OFF_PFA   = 12'h024;
  localparam logic [11:0] OFF_WFA   = 12'h028;
  localparam logic [11:0] OFF_RFA   = 12'h02C;
  localparam logic [11:0] OFF_BEA   = 12'h030;
  localparam logic [11:0] OFF_VER   = 12'h034;

  localparam logic [31:0] CODE_OFF  = 32'h0;
  localparam logic [31:0] CODE_RUN  = 32'h5;
  localparam logic [31:0] CODE_HOLD = 32'h7;

  typedef enum logic [1:0] {MODE_OFF, MODE_RUN, MODE_HOLD} mode_e;

  // Capture groups in register order: page, write side, read side, bus.
  function automatic logic [NFAULT-1:0] grp_mask(input int g);
    case (g)
      0:       return 8'h01;
      1:       return 8'hC4;
      2:       return 8'h32;
      default: return 8'h08;
    endcase
  endfunction
endpackage

// File: rtl/mmu_rf_ctrl.sv
module mmu_rf_ctrl
  import mmu_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        fault_any,
  input  logic        pending,
  output mode_e       mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_OFF;
    end else if (fault_any) begin
      mode <= MODE_HOLD;
    end else if (ctrl_we) begin
      case (ctrl_wdata)
        CODE_OFF:  mode <= MODE_OFF;
        CODE_HOLD: mode <= MODE_HOLD;
        CODE_RUN:  if (!pending) mode <= MODE_RUN;
        default:   mode <= mode;
      endcase
    end
  end
endmodule

// File: rtl/mmu_rf_fault.sv
module mmu_rf_fault
  import mmu_rf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NFAULT-1:0]        evt,
  input  logic [AW-1:0]            evt_addr,
  input  logic                     clr_we,
  input  logic [NFAULT-1:0]        clr_bits,
  output logic [NFAULT-1:0]        status,
  output logic [NGRP-1:0][AW-1:0]  cap_addr
);
  logic [NFAULT-1:0] clr_eff;
  logic [NFAULT-1:0] kept;

  assign clr_eff = clr_we ? clr_bits : '0;
  assign kept    = status & ~clr_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= kept | evt;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_cap
    localparam logic [NFAULT-1:0] GM = grp_mask(g);
    always_ff @(posedge clk) begin
      if (!rst_n)
        cap_addr[g] <= '0;
      else if (((evt & GM) != '0) && ((kept & GM) == '0))
        cap_addr[g] <= evt_addr;
    end
  end
endmodule

// File: rtl/mmu_regfile.sv
module mmu_regfile
  import mmu_rf_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          PAGE_SHIFT  = 12,
  parameter logic [31:0] CFG_WMASK   = 32'h0150_FFFF,
  parameter logic [10:0] VERSION_RAW = 11'h183
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  input  logic [NFAULT-1:0]      fault_evt,
  input  logic [31:0]            fault_addr,
  input  logic                   blocked_ack,
  output logic                   xlate_en,
  output logic                   block_req,
  output logic [31:0]            cfg_q,
  output logic [31:0]            ptbase_q,
  output logic                   flush_all,
  output logic                   flush_entry,
  output logic [31-PAGE_SHIFT:0] flush_vpn,
  output logic                   irq
);
  localparam int VPN_W = 32 - PAGE_SHIFT;

  logic wr, rd;
  assign wr = req_valid &  req_write;
  assign rd = req_valid & ~req_write;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] off);
    return a == ADDR_W'(off);
  endfunction

  mode_e                     mode;
  logic [NFAULT-1:0]         status;
  logic [NGRP-1:0][31:0]     cap_addr;

  mmu_rf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (wr && hit(req_addr, OFF_CTRL)),
    .ctrl_wdata (req_wdata),
    .fault_any  (|fault_evt),
    .pending    (|status),
    .mode       (mode)
  );

  mmu_rf_fault #(.AW(32)) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (fault_evt),
    .evt_addr (fault_addr),
    .clr_we   (wr && hit(req_addr, OFF_ICLR)),
    .clr_bits (req_wdata[NFAULT-1:0]),
    .status   (status),
    .cap_addr (cap_addr)
  );

  assign xlate_en  = (mode == MODE_RUN);
  assign block_req = (mode == MODE_HOLD);
  assign irq       = |status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      ptbase_q    <= '0;
      flush_all   <= 1'b0;
      flush_entry <= 1'b0;
      flush_vpn   <= '0;
    end else begin
      flush_all   <= wr && hit(req_addr, OFF_FLUSH) && req_wdata[0];
      flush_entry <= wr && hit(req_addr, OFF_FLENT) && req_wdata[0];
      if (wr && hit(req_addr, OFF_FLENT) && req_wdata[0])
        flush_vpn <= req_wdata[31 -: VPN_W];
      if (wr && hit(req_addr, OFF_CFG)) cfg_q    <= req_wdata & CFG_WMASK;
      if (wr && hit(req_addr, OFF_PTB)) ptbase_q <= req_wdata;
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if      (hit(req_addr, OFF_CTRL))
      rd_mux = (mode == MODE_RUN) ? CODE_RUN : (mode == MODE_HOLD) ? CODE_HOLD : CODE_OFF;
    else if (hit(req_addr, OFF_CFG))   rd_mux = cfg_q;
    else if (hit(req_addr, OFF_STAT))  rd_mux = {31'b0, block_req & blocked_ack};
    else if (hit(req_addr, OFF_PTB))   rd_mux = ptbase_q;
    else if (hit(req_addr, OFF_ISTAT)) rd_mux = {{(32-NFAULT){1'b0}}, status};
    else if (hit(req_addr, OFF_PFA))   rd_mux = cap_addr[0];
    else if (hit(req_addr, OFF_WFA))   rd_mux = cap_addr[1];
    else if (hit(req_addr, OFF_RFA))   rd_mux = cap_addr[2];
    else if (hit(req_addr, OFF_BEA))   rd_mux = cap_addr[3];
    else if (hit(req_addr, OFF_VER))   rd_mux = {VERSION_RAW, 21'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/mmu_rf_chk.sv
module mmu_rf_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [7:0]        fault_evt,
  input logic              xlate_en,
  input logic              block_req,
  input logic              flush_all,
  input logic              irq
);
  a_r7_fault_forces_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_evt) |=> (block_req && !xlate_en));

  a_r2_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(xlate_en && block_req));

  a_r10_irq_keeps_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !xlate_en);

  a_r12_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  a_r6_flush_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> $past(req_valid && req_write && req_addr == ADDR_W'(12'h00C) && req_wdata[0]));
endmodule

bind mmu_regfile mmu_rf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .fault_evt (fault_evt),
  .xlate_en  (xlate_en),
  .block_req (block_req),
  .flush_all (flush_all),
  .irq       (irq)
);

// File: tb/mmu_regfile_tb.sv
module mmu_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  fault_evt = '0;
  logic [31:0] fault_addr = '0;
  logic        blocked_ack = 1'b0;
  logic        xlate_en, block_req, flush_all, flush_entry, irq;
  logic [31:0] cfg_q, ptbase_q;
  logic [19:0] flush_vpn;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mmu_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .fault_evt(fault_evt), .fault_addr(fault_addr),
    .blocked_ack(blocked_ack), .xlate_en(xlate_en), .block_req(block_req),
    .cfg_q(cfg_q), .ptbase_q(ptbase_q), .flush_all(flush_all),
    .flush_entry(flush_entry), .flush_vpn(flush_vpn), .irq(irq)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic fault(input logic [7:0] e, input logic [31:0] a);
    fault_evt = e; fault_addr = a;
    @(negedge clk);
    fault_evt = '0;
  endtask

  // Monitor: pops expected read data as responses appear.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected response actual=0x%08h expected=none", rsp_rdata);
      end else begin
        cmp(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 irq", {31'b0, irq}, 0);
    cmp("R1 flush", {30'b0, flush_all, flush_entry}, 0);
    rd(12'h000, 32'h0, "R1 ctrl");
    rd(12'h018, 32'h0, "R1 istat");
    rd(12'h008, 32'h0, "R1 status");
    rd(12'h004, 32'h0, "R1 cfg");
    // R9 version: 0x183 in [31:21]
    rd(12'h034, 32'h3060_0000, "R9 version");
    rd(12'h03C, 32'h0, "R12 unmapped");
    rd(12'h00C, 32'h0, "R12 write-only");
    // R3 config mask
    wr(12'h004, 32'hFFFF_FFFF);
    cmp("R3 cfg_q", cfg_q, 32'h0150_FFFF);
    rd(12'h004, 32'h0150_FFFF, "R3 cfg read");
    // R4 table base
    wr(12'h014, 32'h1234_5678);
    cmp("R4 ptbase_q", ptbase_q, 32'h1234_5678);
    rd(12'h014, 32'h1234_5678, "R4 ptbase read");
    // R2 modes
    wr(12'h000, 32'h5);
    cmp("R2 xlate_en", {31'b0, xlate_en}, 1);
    wr(12'h000, 32'h3);
    rd(12'h000, 32'h5, "R2 bad code ignored");
    wr(12'h000, 32'h7);
    cmp("R2 block_req", {30'b0, block_req, xlate_en}, 32'h2);
    // R5 status blocked
    rd(12'h008, 32'h0, "R5 no ack");
    blocked_ack = 1;
    rd(12'h008, 32'h1, "R5 ack");
    blocked_ack = 0;
    wr(12'h000, 32'h0);
    rd(12'h000, 32'h0, "R2 off");
    // R6 flushes
    wr(12'h00C, 32'h1);
    cmp("R6 flush_all pulse", {31'b0, flush_all}, 1);
    @(negedge clk);
    cmp("R6 flush_all one cycle", {31'b0, flush_all}, 0);
    wr(12'h010, 32'hABCD_E001);
    cmp("R6 flush_entry", {11'b0, flush_entry, flush_vpn}, {11'b0, 1'b1, 20'hABCDE});
    @(negedge clk);
    cmp("R6 flush_entry one cycle", {31'b0, flush_entry}, 0);
    wr(12'h010, 32'h1111_1000);
    cmp("R6 bit0 clear no pulse", {31'b0, flush_entry}, 0);
    // R7/R8 read access fault while running
    wr(12'h000, 32'h5);
    fault(8'h20, 32'h4000_0ABC);
    cmp("R7 irq", {31'b0, irq}, 1);
    cmp("R7 held", {30'b0, block_req, xlate_en}, 32'h2);
    rd(12'h018, 32'h20, "R7 istat bit5");
    rd(12'h02C, 32'h4000_0ABC, "R8 read fault addr");
    fault(8'h10, 32'h5555_0000);
    rd(12'h02C, 32'h4000_0ABC, "R8 hold first addr");
    rd(12'h018, 32'h30, "R7 istat bits4,5");
    // R10 enable ignored while pending
    wr(12'h000, 32'h5);
    rd(12'h000, 32'h7, "R10 still held");
    // R11 clear
    wr(12'h01C, 32'h20);
    rd(12'h018, 32'h10, "R11 partial clear");
    wr(12'h01C, 32'h10);
    cmp("R12 irq low", {31'b0, irq}, 0);
    wr(12'h000, 32'h5);
    rd(12'h000, 32'h5, "R10 resume after clear");
    // R8 routing of other classes
    fault(8'h80, 32'hCAFE_0000);
    rd(12'h028, 32'hCAFE_0000, "R8 write prot addr");
    fault(8'h08, 32'hBEEF_0000);
    rd(12'h030, 32'hBEEF_0000, "R8 bus error addr");
    fault(8'h01, 32'h0000_1000);
    rd(12'h024, 32'h0000_1000, "R8 page fault addr");
    rd(12'h018, 32'h89, "R7 istat mix");
    // R11 same-cycle clear and new page fault
    req_valid = 1; req_write = 1; req_addr = 12'h01C; req_wdata = 32'h01;
    fault_evt = 8'h01; fault_addr = 32'h0000_2000;
    @(negedge clk);
    req_valid = 0; req_write = 0; fault_evt = '0;
    rd(12'h018, 32'h89, "R11 set wins");
    rd(12'h024, 32'h0000_2000, "R11 new addr captured");
    wr(12'h01C, 32'hFF);
    rd(12'h018, 32'h0, "R11 all cleared");
    cmp("R12 irq after clear", {31'b0, irq}, 0);
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R12 missing responses actual=%0d expected=0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule